// File: doc/BRIEF.md
# Phase-Gated Delay Line

This block is a chain of registers that holds back a signed fixed-point word by a set number of stages. A repeating phase pattern decides which clock edges may move the chain. With every phase enabled it is a plain pipeline delay. With a sparser pattern it also acts as a decimating sampler: only the words that arrive on the marked phases ever enter the chain, and the rest are dropped.

Two side inputs can be switched on or off at elaboration. One is a clock enable that freezes the chain. The other is a synchronous clear that fills the chain with the reset constant. That constant is zero by default, or a fixed word chosen by parameter. A stage count below one stops elaboration.

The phase pattern is a parameter vector. Its most significant bit governs the first phase after reset, and each following bit governs the next phase.

Top module: `phase_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, every stage loads the reset constant and the phase counter returns to the first phase. `dout` shows the constant from the next edge on.
- R2: With an all-ones pattern, `ena` high and `sclr` low, `dout` equals the `din` value presented STAGES edges earlier.
- R3: The phase counter advances by one on every edge after reset, whatever `ena` and `sclr` do. It wraps from PHASES-1 back to 0. Phase p (0 = first after reset) is enabled when PHASE_MASK[PHASES-1-p] is 1.
- R4: With pattern `2'b10`, only words presented on the first of every two edges are captured, and `dout` does not change on the other edges.
- R5: With pattern `4'b0100`, only the word presented on the second of every four edges enters the chain. Words on phases one, three and four have no effect on `dout`.
- R6: When USE_ENA is 1 and `ena` is low at an edge, with no clear, every stage keeps its value.
- R7: When USE_ENA is 0, `ena` has no effect and the chain advances on every enabled phase.
- R8: When USE_SCLR is 1 and `sclr` is high at an edge, every stage loads the reset constant. This wins over a low `ena` and over a disabled phase.
- R9: When USE_SCLR is 0, `sclr` has no effect on the chain.
- R10: The reset constant is RESET_VALUE when RESET_NONZERO is 1, and all zeros otherwise, even when RESET_VALUE is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | INT_BITS+FRAC_BITS | Data word entering the chain |
| ena | input | 1 | Clock enable, used only when USE_ENA is 1 |
| sclr | input | 1 | Synchronous clear to the reset constant, used only when USE_SCLR is 1 |
| dout | output | INT_BITS+FRAC_BITS | Word leaving the last stage |

## Verification
Four instances with different parameters share the same stimulus:
- an every-phase pattern with three stages,
- the alternating pattern `10` with two stages,
- the one-in-four pattern `0100` with four stages and a zero constant,
- a single stage with both side inputs switched off.

Running the same input through all four shows apart each pattern's choice of captured words, the effect of chain depth, and whether the switched-off inputs are truly ignored. A run of the cycle index as data after a fresh reset pins down exactly which phase the `0100` pattern captures. Directed enable-low and clear stretches, followed by random enable and sparse clears, separate hold from clear and test that clear wins.

// File: rtl/phase_delay_pkg.sv
package phase_delay_pkg;

    // Load/clear strobes shared by every stage of the chain.
    typedef struct packed {
        logic clear;
        logic load;
    } stage_ctrl_t;

    // Width of a counter that spans n phases (at least one bit).
    function automatic int ctr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/phase_seq.sv
module phase_seq
    import phase_delay_pkg::*;
#(
    parameter int                 PHASES     = 1,
    parameter logic [PHASES-1:0]  PHASE_MASK = '1,
    localparam int                PW         = ctr_width(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_q,
    output logic          hit
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    generate
        if (PHASES > 1) begin : g_count
            always_ff @(posedge clk) begin
                if (rst)                  phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                      phase_q <= phase_q + 1'b1;
            end
        end else begin : g_single
            always_ff @(posedge clk) phase_q <= '0;
        end
    endgenerate

    // The leftmost (most significant) bit of the mask belongs to phase 0.
    always_comb hit = PHASE_MASK[PHASES - 1 - int'(phase_q)];

endmodule

// File: rtl/load_ctrl.sv
module load_ctrl
    import phase_delay_pkg::*;
#(
    parameter bit USE_ENA  = 1'b1,
    parameter bit USE_SCLR = 1'b1
) (
    input  logic        ena,
    input  logic        sclr,
    input  logic        hit,
    output stage_ctrl_t ctl
);
    logic ena_eff;

    generate
        if (USE_ENA) begin : g_ena
            assign ena_eff = ena;
        end else begin : g_no_ena
            logic ena_unused;
            assign ena_unused = ena;
            assign ena_eff    = 1'b1;
        end

        if (USE_SCLR) begin : g_clr
            assign ctl.clear = sclr;
        end else begin : g_no_clr
            logic sclr_unused;
            assign sclr_unused = sclr;
            assign ctl.clear   = 1'b0;
        end
    endgenerate

    assign ctl.load = ena_eff & hit;

endmodule

// File: rtl/delay_stage.sv
module delay_stage
    import phase_delay_pkg::*;
#(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  stage_ctrl_t ctl,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || ctl.clear) q <= RST_VAL;
        else if (ctl.load)    q <= d;
    end
endmodule

// File: rtl/phase_delay_line.sv
module phase_delay_line
    import phase_delay_pkg::*;
#(
    parameter int  INT_BITS      = 4,
    parameter int  FRAC_BITS     = 4,
    parameter int  STAGES        = 2,
    parameter int  PHASES        = 1,
    parameter logic [PHASES-1:0] PHASE_MASK = '1,
    parameter bit  USE_ENA       = 1'b1,
    parameter bit  USE_SCLR      = 1'b1,
    parameter bit  RESET_NONZERO = 1'b0,
    parameter logic [INT_BITS+FRAC_BITS-1:0] RESET_VALUE = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [INT_BITS+FRAC_BITS-1:0] din,
    input  logic                          ena,
    input  logic                          sclr,
    output logic [INT_BITS+FRAC_BITS-1:0] dout
);
    localparam int           W    = INT_BITS + FRAC_BITS;
    localparam int           PW   = ctr_width(PHASES);
    localparam logic [W-1:0] RSTV = RESET_NONZERO ? RESET_VALUE : '0;

    generate
        if (STAGES < 1) begin : g_bad_depth
            $fatal(1, "phase_delay_line: STAGES must be at least 1");
        end
    endgenerate

    logic [PW-1:0]         phase_q;
    logic                  phase_hit;
    stage_ctrl_t           ctl;
    logic [STAGES:0][W-1:0] tap;

    phase_seq #(.PHASES(PHASES), .PHASE_MASK(PHASE_MASK)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .hit     (phase_hit)
    );

    load_ctrl #(.USE_ENA(USE_ENA), .USE_SCLR(USE_SCLR)) u_ctl (
        .ena  (ena),
        .sclr (sclr),
        .hit  (phase_hit),
        .ctl  (ctl)
    );

    assign tap[0] = din;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            delay_stage #(.W(W), .RST_VAL(RSTV)) u_stage (
                .clk (clk),
                .rst (rst),
                .ctl (ctl),
                .d   (tap[k]),
                .q   (tap[k+1])
            );
        end
    endgenerate

    assign dout = tap[STAGES];

endmodule

// File: rtl/phase_delay_chk.sv
module phase_delay_chk #(
    parameter int           W        = 8,
    parameter int           PHASES   = 1,
    parameter int           PW       = 1,
    parameter bit           USE_ENA  = 1'b1,
    parameter bit           USE_SCLR = 1'b1,
    parameter logic [W-1:0] RSTV     = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          ena,
    input logic          sclr,
    input logic          hit,
    input logic [PW-1:0] phase,
    input logic [W-1:0]  dout
);
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q) begin
            AST_RESET_CONST: assert (dout == RSTV && phase == '0); // R1
        end
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0)); // R3

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1)); // R3

    AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (rst)
        (!hit && !(USE_SCLR && sclr)) |=> $stable(dout)); // R4

    AST_HOLD_ENA_LOW: assert property (@(posedge clk) disable iff (rst)
        (USE_ENA && !ena && !(USE_SCLR && sclr)) |=> $stable(dout)); // R6

    AST_CLEAR_TO_CONST: assert property (@(posedge clk) disable iff (rst)
        (USE_SCLR && sclr) |=> (dout == RSTV)); // R8

endmodule

bind phase_delay_line phase_delay_chk #(
    .W(W), .PHASES(PHASES), .PW(PW),
    .USE_ENA(USE_ENA), .USE_SCLR(USE_SCLR), .RSTV(RSTV)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ena   (ena),
    .sclr  (sclr),
    .hit   (phase_hit),
    .phase (phase_q),
    .dout  (dout)
);

// File: tb/sim_phase_delay_line.sv
module sim_phase_delay_line;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic         rst  = 1'b1;
    logic         ena  = 1'b1;
    logic         sclr = 1'b0;
    logic [W-1:0] din  = '0;
    logic [W-1:0] dout [4];

    int nchk = 0;
    int nerr = 0;
    string seg = "R1/R10";

    // Per-instance configuration, mirrored from the parameters below.
    int           C_STG [4] = '{3, 2, 4, 1};
    int           C_PH  [4] = '{1, 2, 4, 1};
    logic [3:0]   C_MASK[4] = '{4'b0001, 4'b0010, 4'b0100, 4'b0001};
    bit           C_ENA [4] = '{1'b1, 1'b1, 1'b1, 1'b0};
    bit           C_CLR [4] = '{1'b1, 1'b1, 1'b1, 1'b0};
    // R10: instance 2 has RESET_NONZERO=0, so its constant is zero.
    logic [W-1:0] C_RV  [4] = '{8'h5A, 8'hA5, 8'h00, 8'h11};
    string        ITAG  [4] = '{"R2", "R4", "R5", "R7/R9"};

    phase_delay_line #(.INT_BITS(4), .FRAC_BITS(4), .STAGES(3), .PHASES(1),
        .PHASE_MASK(1'b1), .USE_ENA(1'b1), .USE_SCLR(1'b1),
        .RESET_NONZERO(1'b1), .RESET_VALUE(8'h5A))
    u0 (.clk(clk), .rst(rst), .din(din), .ena(ena), .sclr(sclr), .dout(dout[0]));

    phase_delay_line #(.INT_BITS(4), .FRAC_BITS(4), .STAGES(2), .PHASES(2),
        .PHASE_MASK(2'b10), .USE_ENA(1'b1), .USE_SCLR(1'b1),
        .RESET_NONZERO(1'b1), .RESET_VALUE(8'hA5))
    u1 (.clk(clk), .rst(rst), .din(din), .ena(ena), .sclr(sclr), .dout(dout[1]));

    phase_delay_line #(.INT_BITS(4), .FRAC_BITS(4), .STAGES(4), .PHASES(4),
        .PHASE_MASK(4'b0100), .USE_ENA(1'b1), .USE_SCLR(1'b1),
        .RESET_NONZERO(1'b0), .RESET_VALUE(8'h33))
    u2 (.clk(clk), .rst(rst), .din(din), .ena(ena), .sclr(sclr), .dout(dout[2]));

    phase_delay_line #(.INT_BITS(4), .FRAC_BITS(4), .STAGES(1), .PHASES(1),
        .PHASE_MASK(1'b1), .USE_ENA(1'b0), .USE_SCLR(1'b0),
        .RESET_NONZERO(1'b1), .RESET_VALUE(8'h11))
    u3 (.clk(clk), .rst(rst), .din(din), .ena(ena), .sclr(sclr), .dout(dout[3]));

    // Reference: each instance's chain as an array, plus its phase.
    logic [W-1:0] mdl [4][4];
    int           mph [4];

    function automatic bit mask_on(input int i, input int p);
        return C_MASK[i][C_PH[i] - 1 - p];
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (rst) begin
                for (int k = 0; k < 4; k++) mdl[i][k] = C_RV[i];
                mph[i] = 0;
            end else begin
                if (C_CLR[i] && sclr) begin
                    for (int k = 0; k < 4; k++) mdl[i][k] = C_RV[i];
                end else if ((!C_ENA[i] || ena) && mask_on(i, mph[i])) begin
                    for (int k = 3; k > 0; k--) mdl[i][k] = mdl[i][k-1];
                    mdl[i][0] = din;
                end
                mph[i] = (mph[i] == C_PH[i] - 1) ? 0 : mph[i] + 1;
            end
        end
    end

    task automatic check_all();
        for (int i = 0; i < 4; i++) begin
            logic [W-1:0] exp;
            exp = mdl[i][C_STG[i] - 1];
            nchk++;
            if (dout[i] !== exp) begin
                nerr++;
                $display("FAIL %s u%0d (%s): got %h expected %h", seg, i, ITAG[i], dout[i], exp);
            end
        end
    endtask

    task automatic cyc(input logic e, input logic s, input logic [W-1:0] d);
        @(negedge clk);
        check_all();
        ena = e; sclr = s; din = d;
    endtask

    bit done = 1'b0;

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        seg = "R1/R10";
        check_all();
        rst = 1'b0;

        seg = "R2";
        for (int n = 0; n < 40; n++) cyc(1'b1, 1'b0, W'($urandom));

        // R3: fresh reset, then the cycle index as data
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; din = 8'd0;
        seg = "R3";
        for (int n = 1; n < 24; n++) cyc(1'b1, 1'b0, W'(n));

        seg = "R6";
        for (int n = 0; n < 8; n++) cyc(1'b0, 1'b0, W'($urandom));

        seg = "R8";
        cyc(1'b0, 1'b1, W'($urandom));
        cyc(1'b0, 1'b0, W'($urandom));
        for (int n = 0; n < 6; n++) cyc(1'b1, 1'b0, W'($urandom));

        seg = "R6/R8";
        for (int n = 0; n < 400; n++)
            cyc(($urandom % 10) < 7, ($urandom % 20) == 0, W'($urandom));

        @(negedge clk);
        check_all();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                nchk++; nerr++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule